// File: doc/BRIEF.md
# SPI FIFO Interrupt Status Unit

This block keeps the interrupt state of an SPI master whose transmit and receive paths are byte-wide FIFOs. It combines two kinds of status. Three event flags latch when a one-cycle pulse arrives and hold until software clears them. Four level flags are worked out again every cycle from the FIFO occupancy counts, the FIFO full flags and two programmable thresholds. A mask picks which status bits may raise the single level-sensitive interrupt line. Software sets mask bits through one register and clears them through another.

Writes are single-cycle strobes carrying an address and a data word. Reads are combinational from a separate read address. The FIFO storage and the serial shifter sit outside. They supply the counts, the full flags and the event pulses.

Register selects (`wr_addr`/`rd_addr`): 0 status, 1 mask-set, 2 mask-clear, 3 mask readback, 4 TX threshold, 5 RX threshold. Any other select reads zero.

Top module: `spi_irq_status`

## Requirements
- R1: After a synchronous reset the mask is 0, the three event flags are 0, and both thresholds read back as 1.
- R2: Status bit 0 (RX overflow), bit 1 (mode fail) and bit 6 (TX underflow) are set in the cycle after their event pulse. They stay set while no clearing write addresses them.
- R3: A write to the status register (select 0) clears each event flag whose data bit is 1 and leaves the other event flags unchanged.
- R4: When an event pulse and a status write that clears the same flag arrive in the same cycle, the flag is set afterwards.
- R5: Status bit 2 reads 1 exactly when the TX count is strictly below the TX threshold.
- R6: Status bit 4 reads 1 exactly when the RX count is greater than or equal to the RX threshold.
- R7: Status bit 3 follows the TX full input and bit 5 follows the RX full input, in the same cycle.
- R8: A write to select 1 ORs data bits 6..0 into the mask. A write to select 2 clears the mask bits written as 1. Data bits above 6 have no effect. The mask reads back on select 3.
- R9: `irq` is 1 exactly when some bit in 6..0 is set in both the mask and the status.
- R10: Status writes have no effect on bits 2 to 5. Status bits above 6 always read 0.
- R11: Writes to select 4 and select 5 load the TX and RX thresholds from the low count-width data bits, and the thresholds read back on the same selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register select |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read register select |
| rd_data | output | 32 | Combinational read data |
| tx_count | input | CNT_W (7) | TX FIFO occupancy |
| rx_count | input | CNT_W (7) | RX FIFO occupancy |
| tx_full | input | 1 | TX FIFO full |
| rx_full | input | 1 | RX FIFO full |
| ev_rx_ovf | input | 1 | RX overflow event pulse |
| ev_mode_fail | input | 1 | Mode fail event pulse |
| ev_tx_udf | input | 1 | TX underflow event pulse |
| irq | output | 1 | Level interrupt |

## Verification
The bench drives the TX count to one below the threshold and then to exactly the threshold. It does the same for the RX count. An off-by-one compare shows up as bit 2 or bit 4 flipping one step early or late. It fires an underflow event in the same cycle as a write that clears it. A design where the clear wins would lose that event. It writes ones into the live bit positions and into the upper data bits. A design that stored live bits, or let wide data reach the mask, would show wrong status, mask or `irq` values afterwards.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int NUM_IRQ = 7;
    localparam int ADDR_W  = 3;
    localparam int DATA_W  = 32;

    // status bit positions (software decodes these)
    localparam int BIT_RX_OVF    = 0;
    localparam int BIT_MODE_FAIL = 1;
    localparam int BIT_TX_NFULL  = 2;
    localparam int BIT_TX_FULL   = 3;
    localparam int BIT_RX_NEMPTY = 4;
    localparam int BIT_RX_FULL   = 5;
    localparam int BIT_TX_UDF    = 6;

    localparam logic [NUM_IRQ-1:0] STICKY_MASK = 7'b100_0011;

    typedef enum logic [ADDR_W-1:0] {
        SEL_STATUS = 3'd0,
        SEL_MSET   = 3'd1,
        SEL_MCLR   = 3'd2,
        SEL_MASK   = 3'd3,
        SEL_TXTH   = 3'd4,
        SEL_RXTH   = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic tx_udf;
        logic mode_fail;
        logic rx_ovf;
    } evt_t;

    typedef struct packed {
        logic tx_full;
        logic rx_full;
        logic tx_below;
        logic rx_reached;
    } lvl_t;

    function automatic logic [NUM_IRQ-1:0] place_events(input evt_t e);
        logic [NUM_IRQ-1:0] v;
        v                = '0;
        v[BIT_RX_OVF]    = e.rx_ovf;
        v[BIT_MODE_FAIL] = e.mode_fail;
        v[BIT_TX_UDF]    = e.tx_udf;
        return v;
    endfunction

    function automatic logic [NUM_IRQ-1:0] place_levels(input lvl_t l);
        logic [NUM_IRQ-1:0] v;
        v                = '0;
        v[BIT_TX_NFULL]  = l.tx_below;
        v[BIT_TX_FULL]   = l.tx_full;
        v[BIT_RX_NEMPTY] = l.rx_reached;
        v[BIT_RX_FULL]   = l.rx_full;
        return v;
    endfunction

endpackage

// File: rtl/spi_irq_sticky.sv
module spi_irq_sticky
    import spi_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] set_vec,
    input  logic [NUM_IRQ-1:0] clr_vec,
    output logic [NUM_IRQ-1:0] flags
);
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
        if (STICKY_MASK[i]) begin : g_keep
            logic q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= 1'b0;
                else
                    q <= (q & ~clr_vec[i]) | set_vec[i];
            end
            assign flags[i] = q;
        end else begin : g_none
            assign flags[i] = 1'b0;
        end
    end
endmodule

// File: rtl/spi_irq_level.sv
module spi_irq_level
    import spi_irq_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic [CNT_W-1:0]   tx_count,
    input  logic [CNT_W-1:0]   rx_count,
    input  logic [CNT_W-1:0]   tx_thr,
    input  logic [CNT_W-1:0]   rx_thr,
    input  logic               tx_full,
    input  logic               rx_full,
    output logic [NUM_IRQ-1:0] levels
);
    lvl_t lv;
    always_comb begin
        lv.tx_below   = (tx_count < tx_thr);
        lv.rx_reached = (rx_count >= rx_thr);
        lv.tx_full    = tx_full;
        lv.rx_full    = rx_full;
        levels        = place_levels(lv);
    end
endmodule

// File: rtl/spi_irq_mask.sv
module spi_irq_mask
    import spi_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] set_vec,
    input  logic [NUM_IRQ-1:0] clr_vec,
    output logic [NUM_IRQ-1:0] mask
);
    always_ff @(posedge clk) begin
        if (rst)
            mask <= '0;
        else
            mask <= (mask | set_vec) & ~clr_vec;
    end
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
    import spi_irq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic              tx_full,
    input  logic              rx_full,
    input  logic              ev_rx_ovf,
    input  logic              ev_mode_fail,
    input  logic              ev_tx_udf,
    output logic              irq
);
    localparam logic [CNT_W-1:0] THR_RESET = CNT_W'(1);

    reg_sel_e           wsel;
    reg_sel_e           rsel;
    logic [NUM_IRQ-1:0] wbits;
    logic [NUM_IRQ-1:0] stat_clr;
    logic [NUM_IRQ-1:0] mask_set;
    logic [NUM_IRQ-1:0] mask_clr;
    logic [NUM_IRQ-1:0] ev_vec;
    logic [NUM_IRQ-1:0] sticky_q;
    logic [NUM_IRQ-1:0] level_w;
    logic [NUM_IRQ-1:0] status_w;
    logic [NUM_IRQ-1:0] mask_q;
    logic [CNT_W-1:0]   tx_thr_q;
    logic [CNT_W-1:0]   rx_thr_q;
    evt_t               evt;

    always_comb begin
        wsel     = reg_sel_e'(wr_addr);
        rsel     = reg_sel_e'(rd_addr);
        wbits    = wr_data[NUM_IRQ-1:0];
        stat_clr = (wr_en && wsel == SEL_STATUS) ? (wbits & STICKY_MASK) : '0;
        mask_set = (wr_en && wsel == SEL_MSET) ? wbits : '0;
        mask_clr = (wr_en && wsel == SEL_MCLR) ? wbits : '0;
        evt.rx_ovf    = ev_rx_ovf;
        evt.mode_fail = ev_mode_fail;
        evt.tx_udf    = ev_tx_udf;
        ev_vec   = place_events(evt);
    end

    spi_irq_sticky u_sticky (
        .clk     (clk),
        .rst     (rst),
        .set_vec (ev_vec),
        .clr_vec (stat_clr),
        .flags   (sticky_q)
    );

    spi_irq_level #(.CNT_W(CNT_W)) u_level (
        .tx_count (tx_count),
        .rx_count (rx_count),
        .tx_thr   (tx_thr_q),
        .rx_thr   (rx_thr_q),
        .tx_full  (tx_full),
        .rx_full  (rx_full),
        .levels   (level_w)
    );

    spi_irq_mask u_mask (
        .clk     (clk),
        .rst     (rst),
        .set_vec (mask_set),
        .clr_vec (mask_clr),
        .mask    (mask_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_thr_q <= THR_RESET;
            rx_thr_q <= THR_RESET;
        end else if (wr_en) begin
            if (wsel == SEL_TXTH) tx_thr_q <= wr_data[CNT_W-1:0];
            if (wsel == SEL_RXTH) rx_thr_q <= wr_data[CNT_W-1:0];
        end
    end

    assign status_w = sticky_q | level_w;
    assign irq      = |(status_w & mask_q);

    always_comb begin
        rd_data = '0;
        case (rsel)
            SEL_STATUS: rd_data[NUM_IRQ-1:0] = status_w;
            SEL_MASK:   rd_data[NUM_IRQ-1:0] = mask_q;
            SEL_TXTH:   rd_data[CNT_W-1:0]   = tx_thr_q;
            SEL_RXTH:   rd_data[CNT_W-1:0]   = rx_thr_q;
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/spi_irq_status_chk.sv
module spi_irq_status_chk
    import spi_irq_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [DATA_W-1:0]  wr_data,
    input logic [CNT_W-1:0]   tx_count,
    input logic [CNT_W-1:0]   rx_count,
    input logic               ev_rx_ovf,
    input logic               ev_mode_fail,
    input logic               ev_tx_udf,
    input logic [NUM_IRQ-1:0] status_w,
    input logic [NUM_IRQ-1:0] mask_q,
    input logic [CNT_W-1:0]   tx_thr_q,
    input logic [CNT_W-1:0]   rx_thr_q,
    input logic               irq
);
    logic stat_wr;
    logic mset_wr;
    assign stat_wr = wr_en && (wr_addr == SEL_STATUS);
    assign mset_wr = wr_en && (wr_addr == SEL_MSET);

    a_r2_ovf_latch: assert property (@(posedge clk) disable iff (rst)
        ev_rx_ovf |=> status_w[BIT_RX_OVF]);

    a_r2_mode_latch: assert property (@(posedge clk) disable iff (rst)
        ev_mode_fail |=> status_w[BIT_MODE_FAIL]);

    a_r2_ovf_hold: assert property (@(posedge clk) disable iff (rst)
        (!ev_rx_ovf && !stat_wr) |=> $stable(status_w[BIT_RX_OVF]));

    a_r3_ovf_clear: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && wr_data[BIT_RX_OVF] && !ev_rx_ovf) |=> !status_w[BIT_RX_OVF]);

    a_r4_event_wins: assert property (@(posedge clk) disable iff (rst)
        (ev_tx_udf && stat_wr && wr_data[BIT_TX_UDF]) |=> status_w[BIT_TX_UDF]);

    a_r5_tx_below: assert property (@(posedge clk) disable iff (rst)
        status_w[BIT_TX_NFULL] == (tx_count < tx_thr_q));

    a_r6_rx_reached: assert property (@(posedge clk) disable iff (rst)
        status_w[BIT_RX_NEMPTY] == (rx_count >= rx_thr_q));

    a_r8_mask_set: assert property (@(posedge clk) disable iff (rst)
        mset_wr |=> ((mask_q & $past(wr_data[NUM_IRQ-1:0])) == $past(wr_data[NUM_IRQ-1:0])));

    a_r9_irq_level: assert property (@(posedge clk) disable iff (rst)
        irq == ((mask_q & status_w) != '0));
endmodule

bind spi_irq_status spi_irq_status_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .tx_count     (tx_count),
    .rx_count     (rx_count),
    .ev_rx_ovf    (ev_rx_ovf),
    .ev_mode_fail (ev_mode_fail),
    .ev_tx_udf    (ev_tx_udf),
    .status_w     (status_w),
    .mask_q       (mask_q),
    .tx_thr_q     (tx_thr_q),
    .rx_thr_q     (rx_thr_q),
    .irq          (irq)
);

// File: tb/sim_spi_irq_status.sv
`timescale 1ns/1ps
module sim_spi_irq_status;
    localparam int CW = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [CW-1:0] tx_count = '0;
    logic [CW-1:0] rx_count = '0;
    logic        tx_full = 1'b0;
    logic        rx_full = 1'b0;
    logic        ev_rx_ovf = 1'b0;
    logic        ev_mode_fail = 1'b0;
    logic        ev_tx_udf = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench-side model of the programmed state
    logic [6:0]    sh_sticky = '0;
    logic [6:0]    sh_mask = '0;
    logic [CW-1:0] sh_txth = 1;
    logic [CW-1:0] sh_rxth = 1;

    // scoreboard queues
    logic [31:0] q_dat[$];
    logic        q_irq[$];
    string       q_tag[$];

    always #2 clk = ~clk;

    spi_irq_status u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .tx_count(tx_count), .rx_count(rx_count),
        .tx_full(tx_full), .rx_full(rx_full), .ev_rx_ovf(ev_rx_ovf),
        .ev_mode_fail(ev_mode_fail), .ev_tx_udf(ev_tx_udf), .irq(irq)
    );

    function automatic logic [6:0] model_status();
        logic [6:0] s;
        s    = sh_sticky;
        s[2] = (tx_count < sh_txth);
        s[3] = tx_full;
        s[4] = (rx_count >= sh_rxth);
        s[5] = rx_full;
        return s;
    endfunction

    // monitor: compares at the falling edge
    always @(negedge clk) begin
        if (q_dat.size() > 0) begin
            logic [31:0] ed;
            logic        ei;
            string       tg;
            ed = q_dat.pop_front();
            ei = q_irq.pop_front();
            tg = q_tag.pop_front();
            checks++;
            if (rd_data !== ed || irq !== ei) begin
                errors++;
                $display("FAIL %s rd_data=%h exp=%h irq=%b exp=%b", tg, rd_data, ed, irq, ei);
            end
        end
    end

    task automatic expect_rd(input logic [2:0] sel, input string tag);
        logic [31:0] e;
        e = '0;
        case (sel)
            3'd0: e[6:0] = model_status();
            3'd3: e[6:0] = sh_mask;
            3'd4: e[CW-1:0] = sh_txth;
            3'd5: e[CW-1:0] = sh_rxth;
            default: e = '0;
        endcase
        rd_addr = sel;
        q_dat.push_back(e);
        q_irq.push_back(|(sh_mask & model_status()));
        q_tag.push_back(tag);
        wait (q_dat.size() == 0);
    endtask

    task automatic do_cycle(input logic we, input logic [2:0] a, input logic [31:0] d,
                            input logic [2:0] ev);
        @(posedge clk); #0.5;
        wr_en = we; wr_addr = a; wr_data = d;
        ev_rx_ovf = ev[0]; ev_mode_fail = ev[1]; ev_tx_udf = ev[2];
        @(posedge clk); #0.5;
        wr_en = 1'b0; ev_rx_ovf = 1'b0; ev_mode_fail = 1'b0; ev_tx_udf = 1'b0;
        // update the model after the edge that applied the stimulus
        if (we) begin
            case (a)
                3'd0: sh_sticky = sh_sticky & ~(d[6:0] & 7'b100_0011);
                3'd1: sh_mask   = sh_mask | d[6:0];
                3'd2: sh_mask   = sh_mask & ~d[6:0];
                3'd4: sh_txth   = d[CW-1:0];
                3'd5: sh_rxth   = d[CW-1:0];
                default: ;
            endcase
        end
        sh_sticky = sh_sticky | {ev[2], 4'b0, ev[1], ev[0]};
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        do_cycle(1'b1, a, d, 3'b000);
    endtask

    task automatic pulse(input logic [2:0] ev);
        do_cycle(1'b0, 3'd0, 32'h0, ev);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #0.5 rst = 1'b0;
        @(posedge clk); #0.5;

        // R1 reset state
        expect_rd(3'd0, "R1 status after reset");
        expect_rd(3'd3, "R1 mask after reset");
        expect_rd(3'd4, "R1 tx threshold reset");
        expect_rd(3'd5, "R1 rx threshold reset");

        // R2 event latching and holding
        pulse(3'b001);
        expect_rd(3'd0, "R2 rx overflow latched");
        repeat (3) @(posedge clk); #0.5;
        expect_rd(3'd0, "R2 rx overflow held");
        pulse(3'b110);
        expect_rd(3'd0, "R2 mode fail and underflow latched");

        // R3 selective clear
        wr(3'd0, 32'h0000_0001);
        expect_rd(3'd0, "R3 clear only overflow");

        // R10 writes to live positions and upper bits
        wr(3'd0, 32'hFFFF_FF3C);
        expect_rd(3'd0, "R10 live bits untouched by status write");

        // R4 event beats clear
        do_cycle(1'b1, 3'd0, 32'h0000_0040, 3'b100);
        expect_rd(3'd0, "R4 underflow kept when set and cleared together");
        wr(3'd0, 32'h0000_0042);
        expect_rd(3'd0, "R3 clear remaining flags");

        // R5 tx compare
        tx_count = 7'd5;
        expect_rd(3'd0, "R5 tx count above threshold");
        wr(3'd4, 32'h0000_0008);
        expect_rd(3'd4, "R11 tx threshold readback");
        tx_count = 7'd7;
        expect_rd(3'd0, "R5 tx one below threshold");
        tx_count = 7'd8;
        expect_rd(3'd0, "R5 tx equal to threshold");

        // R6 rx compare
        wr(3'd5, 32'hFFFF_FF83);
        expect_rd(3'd5, "R11 rx threshold readback low bits");
        rx_count = 7'd2;
        expect_rd(3'd0, "R6 rx one below threshold");
        rx_count = 7'd3;
        expect_rd(3'd0, "R6 rx equal to threshold");

        // R7 full flags
        tx_full = 1'b1;
        expect_rd(3'd0, "R7 tx full mirrored");
        tx_full = 1'b0; rx_full = 1'b1;
        expect_rd(3'd0, "R7 rx full mirrored");
        rx_full = 1'b0;

        // R8 mask set / clear
        wr(3'd1, 32'h0000_0011);
        expect_rd(3'd3, "R8 mask set");
        wr(3'd1, 32'hFFFF_FF80);
        expect_rd(3'd3, "R8 upper data bits ignored");
        wr(3'd2, 32'h0000_0001);
        expect_rd(3'd3, "R8 mask clear");

        // R9 irq behaviour
        expect_rd(3'd0, "R9 irq from rx level with mask");
        rx_count = 7'd0;
        expect_rd(3'd0, "R9 irq drops with level");
        wr(3'd1, 32'h0000_0002);
        pulse(3'b010);
        expect_rd(3'd0, "R9 irq from mode fail flag");
        wr(3'd0, 32'h0000_0002);
        expect_rd(3'd0, "R9 irq drops after clear");
        expect_rd(3'd6, "R10 unused select reads zero");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired rd_data=%h exp=done", rd_data);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule